// File: doc/BRIEF.md
# Cascadable Interrupt Source Controller

This block gathers a vector of interrupt request lines, conditions each one by its own sense settings, and latches it into a pending register. Each line can be sensed on a level or on a transition, and active-high/rising or active-low/falling. Pending bits are gated by a mask, and each gated line is steered to one of two registered outputs: an urgent line and an ordinary line. Software works through a small word-wide register port, finds work in a gated pending view, and acknowledges by writing ones into the pending register.

The ordinary output is meant to feed one request line of another instance of the same block, so instances can be stacked. Software then acknowledges the child first and the parent second. Register bit order is reversed with respect to source number: source 0 lives in the most significant bit.

Top module: `intc_ctrl`

## Requirements
- R1: Source n (index n of `irq_src`) appears at register bit NUM_SRC-1-n of every per-source register; with 32 sources, source 0 is bit 31.
- R2: A write to offset 0 (pending) clears each pending bit whose write-data bit is 1; bits written 0 stay unchanged.
- R3: Offset 5 reads pending AND mask. It is read-only: a write to it changes no register.
- R4: A source whose sense bit (offset 4) is 0 is level sensed. While its line is active, its pending bit sets on every cycle, so an acknowledge does not clear it. After the line goes inactive, the bit stays set until acknowledged.
- R5: A source whose sense bit is 1 is transition sensed. One active-going transition sets the bit once. An acknowledge made while the line stays at its active level clears the bit for good.
- R6: Polarity bit (offset 3) 1 means active-high or rising; 0 means active-low or falling. An inactive-going transition never sets an edge source.
- R7: `irq_crit` is the registered OR of gated pending bits whose routing bit (offset 2) is 1. `irq_noncrit` is the registered OR of those whose routing bit is 0. An input change reaches the outputs on the fourth rising edge: two synchronizer stages, the pending register, then the output register.
- R8: A write to the mask (offset 1) never changes pending bits. A masked pending bit raises its output once it is unmasked.
- R9: When a set and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R10: In reset, every register reads zero and both outputs are low. Unused offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Raw request lines, index = source number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for `reg_addr` (combinational) |
| irq_crit | output | 1 | Urgent interrupt output |
| irq_noncrit | output | 1 | Ordinary interrupt output, cascade source |

## Verification
Every one of the 32 sources is swept one-hot in level mode with a mixed routing pattern. This separates bit-order mistakes from routing mistakes and shows that level sources cannot be acknowledged while held. A second sweep puts all sources in transition mode with alternating polarities. Driving each line active and then back to idle tells rising from falling and confirms that the return transition is ignored. Directed cases cover:
- partial acknowledge masks;
- masking while a bit is pending;
- a transition landing in the same cycle as its acknowledge;
- a write to the read-only gated view.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DEF_SRC = 32;
    localparam int REG_AW  = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_PEND   = 3'd0,
        REG_MASK   = 3'd1,
        REG_ROUTE  = 3'd2,
        REG_POL    = 3'd3,
        REG_SENSE  = 3'd4,
        REG_GATED  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic             we;
        logic [REG_AW-1:0] addr;
    } reg_req_t;

    function automatic logic hits(input reg_req_t r, input reg_sel_e s);
        return r.we && (r.addr == s);
    endfunction

endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int N = intc_pkg::DEF_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_raw,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] sense,
    output logic [N-1:0] set_req
);
    for (genvar n = 0; n < N; n++) begin : g_src
        localparam int B = N - 1 - n;
        logic s1, s2, prev;
        logic act_now, act_prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= irq_raw[n];
                s2   <= s1;
                prev <= s2;
            end
        end

        always_comb begin
            act_now    = ~(s2 ^ pol[B]);
            act_prev   = ~(prev ^ pol[B]);
            set_req[B] = sense[B] ? (act_now & ~act_prev) : act_now;
        end

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && sense[B] && $past(sense[B]) && $stable(pol[B]) && $past(set_req[B]))
            |-> !set_req[B]) else $error("edge set lasted two cycles"); // R5
    end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N = DEF_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      set_req,
    output logic [N-1:0]      pend,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      route,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      sense,
    output logic [N-1:0]      rdata
);
    reg_req_t     req;
    logic [N-1:0] ack;

    always_comb begin
        req.we   = we;
        req.addr = addr;
        ack      = hits(req, REG_PEND) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            mask  <= '0;
            route <= '0;
            pol   <= '0;
            sense <= '0;
        end else begin
            pend <= (pend & ~ack) | set_req;
            if (hits(req, REG_MASK))  mask  <= wdata;
            if (hits(req, REG_ROUTE)) route <= wdata;
            if (hits(req, REG_POL))   pol   <= wdata;
            if (hits(req, REG_SENSE)) sense <= wdata;
        end
    end

    always_comb begin
        case (addr)
            REG_PEND:  rdata = pend;
            REG_MASK:  rdata = mask;
            REG_ROUTE: rdata = route;
            REG_POL:   rdata = pol;
            REG_SENSE: rdata = sense;
            REG_GATED: rdata = pend & mask;
            default:   rdata = '0;
        endcase
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((pend & $past(set_req)) == $past(set_req)))
        else $error("set lost"); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(we && addr == REG_PEND))
        |-> ((pend & $past(wdata) & ~$past(set_req)) == '0))
        else $error("ack did not clear"); // R2

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(we && addr == REG_PEND))
        |-> ((pend & $past(pend)) == $past(pend)))
        else $error("pending bit dropped without ack"); // R8

    AST_GATED_RO: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(we && addr == REG_GATED))
        |-> ($stable(mask) && $stable(route) && $stable(pol) && $stable(sense)))
        else $error("read-only write changed config"); // R3

endmodule

// File: rtl/intc_route.sv
module intc_route #(
    parameter int N = intc_pkg::DEF_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] route,
    output logic         irq_crit,
    output logic         irq_noncrit
);
    logic [N-1:0] gated;

    always_comb gated = pend & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_crit    <= 1'b0;
            irq_noncrit <= 1'b0;
        end else begin
            irq_crit    <= |(gated & route);
            irq_noncrit <= |(gated & ~route);
        end
    end

    AST_CRIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_crit |-> ($past(!rst) && ($past(mask & route) != '0)))
        else $error("urgent output without enabled urgent source"); // R7

    AST_NONCRIT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_noncrit |-> ($past(!rst) && ($past(pend & ~route) != '0)))
        else $error("ordinary output without ordinary pending source"); // R7

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_SRC = DEF_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_crit,
    output logic               irq_noncrit
);
    logic [NUM_SRC-1:0] set_req, pend, mask, route, pol, sense;

    intc_src_cond #(.N(NUM_SRC)) u_cond (
        .clk(clk), .rst(rst), .irq_raw(irq_src),
        .pol(pol), .sense(sense), .set_req(set_req)
    );

    intc_regs #(.N(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .set_req(set_req), .pend(pend), .mask(mask), .route(route),
        .pol(pol), .sense(sense), .rdata(reg_rdata)
    );

    intc_route #(.N(NUM_SRC)) u_route (
        .clk(clk), .rst(rst), .pend(pend), .mask(mask), .route(route),
        .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_crit && !irq_noncrit))
        else $error("output high right after reset"); // R10

endmodule

// File: tb/tb_intc_ctrl.sv
module tb_intc_ctrl;
    localparam int N = 32;
    localparam logic [N-1:0] CRITP = 32'h0F0F_0F0F;
    localparam logic [N-1:0] PPAT  = 32'hAAAA_5555;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_src = '0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic irq_crit, irq_noncrit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_ctrl dut (
        .clk(clk), .rst(rst), .irq_src(irq_src), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
    );

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d, bitv, idle;
        repeat (3) @(negedge clk);
        // R10: reset values and unused offsets
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            check("R10 reset read", d, '0);
        end
        check("R10 reset outputs", {30'd0, irq_crit, irq_noncrit}, '0);
        @(negedge clk); rst = 1'b0;

        wr(3, '1); wr(4, '0); wr(1, '1); wr(2, CRITP);
        settle(); wr(0, '1); settle();
        rd(0, d); check("R2 clear all", d, '0);

        // Level sweep, one-hot: R1 R3 R4 R7 R2
        for (int n = 0; n < N; n++) begin
            bitv = '0; bitv[N-1-n] = 1'b1;
            irq_src = '0; irq_src[n] = 1'b1;
            settle();
            rd(0, d); check("R1 bit order", d, bitv);
            rd(5, d); check("R3 gated view", d, bitv);
            check("R7 urgent", {31'd0, irq_crit}, {31'd0, CRITP[N-1-n]});
            check("R7 ordinary", {31'd0, irq_noncrit}, {31'd0, ~CRITP[N-1-n]});
            wr(0, '1); settle();
            rd(0, d); check("R4 held level not cleared", d, bitv);
            irq_src = '0; settle();
            rd(0, d); check("R4 latched after drop", d, bitv);
            wr(0, bitv); settle();
            rd(0, d); check("R2 ack one", d, '0);
            check("R7 outputs low", {30'd0, irq_crit, irq_noncrit}, '0);
        end

        // R2: zero bits unaffected
        irq_src = 32'h0000_0006; settle(); irq_src = '0; settle();
        wr(0, 32'h2000_0000); settle();
        rd(0, d); check("R2 partial ack", d, 32'h4000_0000);
        wr(0, '1);

        // Edge sweep with mixed polarity: R5 R6
        wr(3, PPAT); wr(4, '1);
        for (int n = 0; n < N; n++) idle[n] = ~PPAT[N-1-n];
        irq_src = idle; settle(); wr(0, '1); settle();
        rd(0, d); check("R5 idle edge quiet", d, '0);
        for (int n = 0; n < N; n++) begin
            bitv = '0; bitv[N-1-n] = 1'b1;
            irq_src = idle; irq_src[n] = ~idle[n];
            settle();
            rd(0, d); check("R6 active transition sets", d, bitv);
            wr(0, bitv); settle();
            rd(0, d); check("R5 ack while held", d, '0);
            irq_src = idle; settle();
            rd(0, d); check("R6 return transition ignored", d, '0);
        end

        // R6: active-low level
        wr(3, '0); wr(4, '0); irq_src = '1; settle(); wr(0, '1); settle();
        rd(0, d); check("R6 low-level idle", d, '0);
        irq_src[5] = 1'b0; settle();
        rd(0, d); check("R6 low-level set", d, 32'h0400_0000);
        irq_src = '1; settle(); wr(0, '1);

        // R8: mask does not clear pending
        wr(3, '1); irq_src = '0; settle(); wr(0, '1); wr(1, '0);
        irq_src[3] = 1'b1; settle(); irq_src = '0; settle();
        rd(0, d); check("R8 pending while masked", d, 32'h1000_0000);
        rd(5, d); check("R3 gated masked", d, '0);
        check("R7 masked outputs low", {30'd0, irq_crit, irq_noncrit}, '0);
        wr(1, 32'h1000_0000); settle();
        check("R8 unmask raises ordinary", {31'd0, irq_noncrit}, 32'd1);
        wr(1, '0); settle();
        rd(0, d); check("R8 remask keeps pending", d, 32'h1000_0000);
        check("R8 remask drops output", {31'd0, irq_noncrit}, 32'd0);
        wr(0, '1);

        // R3: write to gated view ignored
        wr(5, '1); settle();
        rd(1, d); check("R3 mask unchanged", d, '0);
        rd(2, d); check("R3 route unchanged", d, CRITP);
        rd(3, d); check("R3 pol unchanged", d, '1);

        // R9: edge set and ack in the same cycle
        wr(4, '1); settle(); wr(0, '1); settle();
        @(negedge clk); irq_src[7] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = '1;
        @(negedge clk); reg_we = 1'b0;
        rd(0, d); check("R9 set wins", d, 32'h0100_0000);
        wr(0, '1); settle();
        rd(0, d); check("R9 later ack clears", d, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule